// File: doc/BRIEF.md
# Sticky Error Status Register

This block gathers error events from a small dual-motor driver that is steered over a serial link, and keeps them in an 8-bit status byte. Each bit latches when its event occurs and stays set until the host issues the read-error command. That command hands the byte back and empties it in the same step. Two conditions are qualified before they are latched. An over-current comparator result counts only when that motor's limit is nonzero and the limit-response setting is zero, which is the mode where the driver does not regulate. The top bit comes from a built-in inactivity timer that counts millisecond ticks between received packets.

The block watches the received byte stream for the read command in either of two framings. In compact framing the command is one byte. In addressed framing it is a start byte, then a device identifier, then an opcode. While any bit is set, the block lights the red LED, drives the open-drain error pin high and, if shutdown is enabled, asks both motors to stop. Strobes and flags stand in for the receiver, the packet parser and the CRC logic.

Top module: `err_status_reg`

## Requirements
- R1: Each event sets its own bit of `err_byte_o`. From bit 0 upward the bits are: motor 0 fault, motor 1 fault, motor 0 over-current, motor 1 over-current, serial hardware, CRC, format, timeout. A bit sampled at a clock edge is visible after that edge.
- R2: A set bit stays set until a read command is accepted.
- R3: A received byte 0x82 is a compact read. At the edge where it is accepted the register is cleared. After that edge `rd_strobe_o` is high for one cycle, and `rd_data_o` holds the value the register had before the clear.
- R4: The byte sequence 0xAA, then a byte equal to `{0, dev_id_i}`, then 0x02 is an addressed read that behaves as in R3. Any other identifier, or a lone 0x02, is ignored.
- R5: An over-current bit is set only when that motor's comparator is high, its limit is nonzero, and `limit_resp_i` is zero.
- R6: The serial hardware bit (bit 4) is set by a missing stop bit or by a receive overrun.
- R7: With `tmo_cfg_i` = N > 0, bit 7 is set at the edge N*TICK_DIV cycles after the last edge where `pkt_rcvd_i` was high. Each packet restarts the count, and the bit is set only once per expiry.
- R8: `tmo_cfg_i` = 0 disables the timer, so bit 7 is never set.
- R9: While the register is nonzero, `err_pin_oe_o`, `err_pin_o` and `led_red_o` are high. While it is zero, all three are low, and an output-enable of 0 means the pin is high-impedance.
- R10: With `shdn_en_i` high, any of bits 0 to 6 set drives `motor_stop_o` high until the register is cleared.
- R11: An event that arrives in the same cycle as an accepted read survives the clear. It is absent from `rd_data_o` and present in `err_byte_o`.
- R12: The timeout bit raises `motor_stop_o` only when `tmo_shdn_i` and `shdn_en_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_byte_i | input | 8 | Received serial byte |
| rx_valid_i | input | 1 | `rx_byte_i` valid this cycle |
| dev_id_i | input | 7 | Device identifier for addressed framing |
| pkt_rcvd_i | input | 1 | Pulse: a complete command packet was received |
| drv_fault_i | input | 2 | Driver fault line per motor |
| oc_cmp_i | input | 2 | Current-above-limit comparator per motor |
| cur_limit_i | input | 2 x LIM_W | Current limit per motor (0 = limiting off) |
| limit_resp_i | input | RESP_W | Limit response setting (0 = flag instead of regulate) |
| stop_bit_err_i | input | 1 | Missing stop bit |
| rx_overrun_i | input | 1 | Receive buffer overflow |
| crc_err_i | input | 1 | Pulse: packet CRC mismatch |
| fmt_err_i | input | 1 | Pulse: malformed packet |
| tmo_cfg_i | input | TMO_W | Timeout in millisecond ticks, 0 = off |
| shdn_en_i | input | 1 | Shutdown-on-error enable |
| tmo_shdn_i | input | 1 | Treat timeout as a shutdown cause |
| err_byte_o | output | 8 | Live sticky error byte |
| rd_strobe_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Error byte returned by the last read |
| err_pin_oe_o | output | 1 | Error pin output enable |
| err_pin_o | output | 1 | Error pin output value |
| led_red_o | output | 1 | Red status LED |
| motor_stop_o | output | 1 | Stop request to both motors |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a read clear and a fresh event. The bench drives the final byte of a read together with a CRC or format pulse. It expects the returned byte to lack the new bit and the live register to keep it. The second pair is a packet arrival and the timer's final tick. The bench places packets just short of expiry and checks that bit 7 stays low, while a reference model compares every output on every cycle.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int ERR_W  = 8;
  localparam int BYTE_W = 8;
  localparam int MOT_N  = 2;

  localparam int B_FLT0 = 0;
  localparam int B_OC0  = 2;
  localparam int B_SER  = 4;
  localparam int B_CRC  = 5;
  localparam int B_FMT  = 6;
  localparam int B_TMO  = 7;

  localparam logic [BYTE_W-1:0] CMD_SHORT_READ = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_ADDR_START = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_ADDR_READ  = 8'h02;

  localparam logic [ERR_W-1:0] STOP_MASK = 8'h7F;

  typedef enum logic [1:0] {
    CD_IDLE,
    CD_WAIT_ID,
    CD_WAIT_OP
  } cmd_state_e;
endpackage

// File: rtl/err_rst_sync.sv
module err_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sno
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sno = sync_q[1];
endmodule

// File: rtl/err_cmd_detect.sv
module err_cmd_detect
  import err_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic [BYTE_W-2:0] dev_id_i,
  output logic              read_o
);
  cmd_state_e state_q, state_d;
  logic       is_cmd_byte;

  assign is_cmd_byte = byte_i[BYTE_W-1];

  always_comb begin
    state_d = state_q;
    read_o  = 1'b0;
    if (valid_i) begin
      if (is_cmd_byte) begin
        // a command byte always aborts whatever was in progress
        state_d = CD_IDLE;
        if (byte_i == CMD_SHORT_READ) read_o  = 1'b1;
        if (byte_i == CMD_ADDR_START) state_d = CD_WAIT_ID;
      end else begin
        unique case (state_q)
          CD_WAIT_ID: state_d = (byte_i[BYTE_W-2:0] == dev_id_i) ? CD_WAIT_OP : CD_IDLE;
          CD_WAIT_OP: begin
            state_d = CD_IDLE;
            read_o  = (byte_i == CMD_ADDR_READ);
          end
          default:    state_d = CD_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      state_q <= CD_IDLE;
    else if (valid_i) state_q <= state_d;
  end
endmodule

// File: rtl/err_idle_timer.sv
module err_idle_timer #(
  parameter int TICK_DIV = 100000,
  parameter int CFG_W    = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             pkt_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             expire_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]    presc_q, presc_d;
  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             tick;
  logic             armed;
  logic [CFG_W:0]   cnt_inc;

  assign tick    = (presc_q == PRESC_LAST);
  assign armed   = (cfg_i != '0) && !done_q;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    presc_d  = tick ? '0 : presc_q + 1'b1;
    cnt_d    = cnt_q;
    done_d   = done_q;
    expire_o = 1'b0;
    if (pkt_i) begin
      presc_d = '0;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (tick && armed) begin
      if (cnt_inc >= {1'b0, cfg_i}) begin
        done_d   = 1'b1;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_inc[CFG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      presc_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      presc_q <= presc_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/err_event_map.sv
module err_event_map
  import err_status_pkg::*;
#(
  parameter int LIM_W  = 8,
  parameter int RESP_W = 8
) (
  input  logic [MOT_N-1:0]            fault_i,
  input  logic [MOT_N-1:0]            oc_cmp_i,
  input  logic [MOT_N-1:0][LIM_W-1:0] limit_i,
  input  logic [RESP_W-1:0]           resp_i,
  input  logic                        stop_bit_err_i,
  input  logic                        overrun_i,
  input  logic                        crc_err_i,
  input  logic                        fmt_err_i,
  input  logic                        tmo_i,
  output logic [ERR_W-1:0]            evt_o
);
  logic flag_mode;

  // over-current is only reported when the driver is not regulating
  assign flag_mode = (resp_i == '0);

  for (genvar m = 0; m < MOT_N; m++) begin : g_mot
    assign evt_o[B_FLT0 + m] = fault_i[m];
    assign evt_o[B_OC0 + m]  = oc_cmp_i[m] && (limit_i[m] != '0) && flag_mode;
  end

  assign evt_o[B_SER] = stop_bit_err_i | overrun_i;
  assign evt_o[B_CRC] = crc_err_i;
  assign evt_o[B_FMT] = fmt_err_i;
  assign evt_o[B_TMO] = tmo_i;
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_status_pkg::*;
#(
  parameter int TICK_DIV = 100000,
  parameter int TMO_W    = 8,
  parameter int LIM_W    = 8,
  parameter int RESP_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            rx_byte_i,
  input  logic                  rx_valid_i,
  input  logic [6:0]            dev_id_i,
  input  logic                  pkt_rcvd_i,
  input  logic [1:0]            drv_fault_i,
  input  logic [1:0]            oc_cmp_i,
  input  logic [1:0][LIM_W-1:0] cur_limit_i,
  input  logic [RESP_W-1:0]     limit_resp_i,
  input  logic                  stop_bit_err_i,
  input  logic                  rx_overrun_i,
  input  logic                  crc_err_i,
  input  logic                  fmt_err_i,
  input  logic [TMO_W-1:0]      tmo_cfg_i,
  input  logic                  shdn_en_i,
  input  logic                  tmo_shdn_i,
  output logic [7:0]            err_byte_o,
  output logic                  rd_strobe_o,
  output logic [7:0]            rd_data_o,
  output logic                  err_pin_oe_o,
  output logic                  err_pin_o,
  output logic                  led_red_o,
  output logic                  motor_stop_o
);
  logic             rst_sn;
  logic             rd_fire;
  logic             tmo_evt;
  logic [ERR_W-1:0] evt;
  logic [ERR_W-1:0] err_q, err_d;
  logic [ERR_W-1:0] rdat_q;
  logic             rstb_q;
  logic             any_err;
  logic             stop_cause;

  err_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_sno(rst_sn)
  );

  err_cmd_detect u_cmd (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .byte_i  (rx_byte_i),
    .valid_i (rx_valid_i),
    .dev_id_i(dev_id_i),
    .read_o  (rd_fire)
  );

  err_idle_timer #(
    .TICK_DIV(TICK_DIV),
    .CFG_W   (TMO_W)
  ) u_timer (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .pkt_i   (pkt_rcvd_i),
    .cfg_i   (tmo_cfg_i),
    .expire_o(tmo_evt)
  );

  err_event_map #(
    .LIM_W (LIM_W),
    .RESP_W(RESP_W)
  ) u_map (
    .fault_i       (drv_fault_i),
    .oc_cmp_i      (oc_cmp_i),
    .limit_i       (cur_limit_i),
    .resp_i        (limit_resp_i),
    .stop_bit_err_i(stop_bit_err_i),
    .overrun_i     (rx_overrun_i),
    .crc_err_i     (crc_err_i),
    .fmt_err_i     (fmt_err_i),
    .tmo_i         (tmo_evt),
    .evt_o         (evt)
  );

  // clear first, then merge: an event on the read edge is kept
  always_comb begin
    err_d = rd_fire ? '0 : err_q;
    err_d = err_d | evt;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      err_q  <= '0;
      rdat_q <= '0;
      rstb_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      rstb_q <= rd_fire;
      if (rd_fire) rdat_q <= err_q;
    end
  end

  assign any_err    = (err_q != '0);
  assign stop_cause = ((err_q & STOP_MASK) != '0) || (tmo_shdn_i && err_q[B_TMO]);

  assign err_byte_o   = err_q;
  assign rd_strobe_o  = rstb_q;
  assign rd_data_o    = rdat_q;
  assign err_pin_oe_o = any_err;
  assign err_pin_o    = any_err;
  assign led_red_o    = any_err;
  assign motor_stop_o = shdn_en_i && stop_cause;
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int RESP_W = 8,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              rd_fire,
  input logic [7:0]        err_byte_o,
  input logic [7:0]        rd_data_o,
  input logic              rd_strobe_o,
  input logic              err_pin_oe_o,
  input logic              err_pin_o,
  input logic              crc_err_i,
  input logic [RESP_W-1:0] limit_resp_i,
  input logic [CFG_W-1:0]  tmo_cfg_i
);
  // R2: without a read no set bit may drop
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_fire |=> ((err_byte_o & $past(err_byte_o)) == $past(err_byte_o)));

  // R3: a read returns the pre-clear byte one cycle later
  p_read_ret_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_fire |=> (rd_strobe_o && rd_data_o == $past(err_byte_o)));

  // R5: a non-zero response setting blocks the over-current bits
  p_oc_block_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (limit_resp_i != '0 && err_byte_o[3:2] == 2'b00) |=> err_byte_o[3:2] == 2'b00);

  // R8: a disabled timer never raises the timeout bit
  p_tmo_off_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (tmo_cfg_i == '0 && !err_byte_o[7]) |=> !err_byte_o[7]);

  // R9: an enabled pin is always driven high
  p_pin_high_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    err_pin_oe_o |-> err_pin_o);

  // R11: an event on the read edge survives the clear
  p_survive_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_fire && crc_err_i) |=> (err_byte_o[5] && !rd_data_o[5]) || $past(err_byte_o[5]));
endmodule

bind err_status_reg err_status_chk #(
  .RESP_W(RESP_W),
  .CFG_W (TMO_W)
) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .rd_fire     (rd_fire),
  .err_byte_o  (err_byte_o),
  .rd_data_o   (rd_data_o),
  .rd_strobe_o (rd_strobe_o),
  .err_pin_oe_o(err_pin_oe_o),
  .err_pin_o   (err_pin_o),
  .crc_err_i   (crc_err_i),
  .limit_resp_i(limit_resp_i),
  .tmo_cfg_i   (tmo_cfg_i)
);

// File: tb/err_status_reg_bench.sv
module err_status_reg_bench;
  localparam int DIV = 4;

  logic            clk;
  logic            rst_n;
  logic [7:0]      rx_byte;
  logic            rx_valid;
  logic [6:0]      dev_id;
  logic            pkt;
  logic [1:0]      fault;
  logic [1:0]      oc;
  logic [1:0][7:0] lim;
  logic [7:0]      resp;
  logic            stop_err;
  logic            ovr;
  logic            crc;
  logic            fmt;
  logic [7:0]      tcfg;
  logic            shdn;
  logic            tshdn;
  logic [7:0]      err_byte;
  logic            rd_stb;
  logic [7:0]      rd_data;
  logic            pin_oe;
  logic            pin_v;
  logic            led;
  logic            mstop;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  err_status_reg #(.TICK_DIV(DIV)) u_err_status_reg (
    .clk(clk), .rst_n(rst_n), .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
    .dev_id_i(dev_id), .pkt_rcvd_i(pkt), .drv_fault_i(fault), .oc_cmp_i(oc),
    .cur_limit_i(lim), .limit_resp_i(resp), .stop_bit_err_i(stop_err),
    .rx_overrun_i(ovr), .crc_err_i(crc), .fmt_err_i(fmt), .tmo_cfg_i(tcfg),
    .shdn_en_i(shdn), .tmo_shdn_i(tshdn), .err_byte_o(err_byte),
    .rd_strobe_o(rd_stb), .rd_data_o(rd_data), .err_pin_oe_o(pin_oe),
    .err_pin_o(pin_v), .led_red_o(led), .motor_stop_o(mstop)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // behavioural reference
  int        warm;
  bit [7:0]  m_err, m_rd;
  bit        m_stb;
  int        m_phase;
  int        idle_cyc;
  bit        m_expired;

  always @(posedge clk or negedge rst_n) begin
    bit [7:0] ev;
    bit       rd;
    if (!rst_n) begin
      warm = 0; m_err = 0; m_rd = 0; m_stb = 0; m_phase = 0;
      idle_cyc = 0; m_expired = 0;
    end else if (warm < 2) begin
      warm++;
    end else begin
      ev = 0;
      ev[0] = fault[0];
      ev[1] = fault[1];
      for (int m = 0; m < 2; m++)
        if (oc[m] && lim[m] != 0 && resp == 0) ev[2+m] = 1;
      ev[4] = stop_err || ovr;
      ev[5] = crc;
      ev[6] = fmt;
      if (pkt) begin
        idle_cyc = 0; m_expired = 0;
      end else begin
        idle_cyc++;
        if (tcfg != 0 && !m_expired && idle_cyc == int'(tcfg) * DIV) begin
          ev[7] = 1; m_expired = 1;
        end
      end
      rd = 0;
      if (rx_valid) begin
        if (rx_byte == 8'h82) begin rd = 1; m_phase = 0; end
        else if (rx_byte == 8'hAA) m_phase = 1;
        else if (rx_byte >= 8'h80) m_phase = 0;
        else if (m_phase == 1) m_phase = (rx_byte == {1'b0, dev_id}) ? 2 : 0;
        else if (m_phase == 2) begin rd = (rx_byte == 8'h02); m_phase = 0; end
      end
      m_stb = rd;
      if (rd) m_rd = m_err;
      m_err = (rd ? 8'h00 : m_err) | ev;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle
  always @(negedge clk) begin
    bit e_stop;
    if (rst_n && !done) begin
      e_stop = shdn && (((m_err & 8'h7F) != 0) || (tshdn && m_err[7]));
      chk("R2 err_byte", int'(err_byte), int'(m_err));
      chk("R3 rd_strobe", int'(rd_stb), int'(m_stb));
      if (m_stb) chk("R3 rd_data", int'(rd_data), int'(m_rd));
      chk("R9 pin_oe", int'(pin_oe), int'(m_err != 0));
      chk("R9 pin_val", int'(pin_v), int'(m_err != 0));
      chk("R9 led", int'(led), int'(m_err != 0));
      chk("R10 motor_stop", int'(mstop), int'(e_stop));
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1; cyc(); rx_valid = 0;
  endtask

  initial begin
    rst_n = 0; rx_byte = 0; rx_valid = 0; dev_id = 7'h0A; pkt = 0;
    fault = 0; oc = 0; lim = '0; resp = 0; stop_err = 0; ovr = 0;
    crc = 0; fmt = 0; tcfg = 0; shdn = 0; tshdn = 0;
    cyc(3); rst_n = 1; cyc(4);
    chk("R9 reset byte", int'(err_byte), 0);
    chk("R9 reset pin", int'(pin_oe), 0);

    // R1 and R2
    fault[0] = 1; cyc(); fault[0] = 0;
    chk("R1 m0 fault", int'(err_byte), 8'h01);
    cyc(5);
    chk("R2 hold", int'(err_byte), 8'h01);
    // R3 compact read
    send(8'h82);
    chk("R3 strobe", int'(rd_stb), 1);
    chk("R3 data", int'(rd_data), 8'h01);
    chk("R3 cleared", int'(err_byte), 0);
    chk("R9 pin released", int'(pin_oe), 0);

    // R5 over-current conditions
    lim[0] = 8'd10; resp = 8'd5; oc[0] = 1; cyc(3);
    chk("R5 regulating", int'(err_byte), 0);
    lim[0] = 0; resp = 0; cyc(3);
    chk("R5 zero limit", int'(err_byte), 0);
    lim[0] = 8'd10; cyc(); oc[0] = 0;
    chk("R5 flagged", int'(err_byte), 8'h04);
    lim[1] = 8'd3; oc[1] = 1; cyc(); oc[1] = 0;
    chk("R1 m1 oc", int'(err_byte), 8'h0C);
    send(8'h82);

    // R6 serial hardware
    stop_err = 1; cyc(); stop_err = 0;
    chk("R6 stop bit", int'(err_byte), 8'h10);
    send(8'h82);
    ovr = 1; cyc(); ovr = 0;
    chk("R6 overrun", int'(err_byte), 8'h10);
    crc = 1; fmt = 1; cyc(); crc = 0; fmt = 0;
    chk("R1 crc fmt", int'(err_byte), 8'h70);

    // R4 addressed read
    send(8'h02); cyc();
    chk("R4 lone op", int'(err_byte), 8'h70);
    send(8'hAA); send(8'h0B); send(8'h02);
    chk("R4 wrong id strobe", int'(rd_stb), 0);
    chk("R4 wrong id kept", int'(err_byte), 8'h70);
    send(8'hAA); send(8'h0A); send(8'h02);
    chk("R4 addressed strobe", int'(rd_stb), 1);
    chk("R4 addressed data", int'(rd_data), 8'h70);
    chk("R4 addressed cleared", int'(err_byte), 0);

    // R10 shutdown
    shdn = 1;
    fault[1] = 1; cyc(); fault[1] = 0; cyc(3);
    chk("R10 stop held", int'(mstop), 1);
    send(8'h82);
    chk("R10 stop released", int'(mstop), 0);

    // R7 timeout and R12
    tcfg = 8'd3; pkt = 1; cyc(); pkt = 0;
    cyc(11);
    chk("R7 not yet", int'(err_byte[7]), 0);
    cyc();
    chk("R7 expired", int'(err_byte[7]), 1);
    chk("R12 no stop", int'(mstop), 0);
    tshdn = 1; #1;
    chk("R12 stop", int'(mstop), 1);
    tshdn = 0;
    pkt = 1; cyc(); pkt = 0;
    send(8'h82);
    repeat (3) begin cyc(10); pkt = 1; cyc(); pkt = 0; end
    chk("R7 restarted", int'(err_byte[7]), 0);
    cyc(12);
    chk("R7 once", int'(err_byte), 8'h80);
    cyc(30);
    send(8'h82);
    cyc(20);
    chk("R7 single fire", int'(err_byte), 0);

    // R8 disabled
    tcfg = 0; pkt = 1; cyc(); pkt = 0;
    cyc(60);
    chk("R8 disabled", int'(err_byte[7]), 0);

    // R11 same-cycle clear and event
    fmt = 1; cyc(); fmt = 0;
    rx_byte = 8'h82; rx_valid = 1; crc = 1; cyc(); rx_valid = 0; crc = 0;
    chk("R11 returned", int'(rd_data), 8'h40);
    chk("R11 survived", int'(err_byte), 8'h20);
    send(8'hAA); send(8'h0A); fmt = 1; send(8'h02); fmt = 0;
    chk("R11 addressed returned", int'(rd_data), 8'h20);
    chk("R11 addressed survived", int'(err_byte), 8'h40);
    cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule